// File: doc/BRIEF.md
# Stack Machine Datapath Register and Bus Unit

This unit holds the working registers of a 32-bit microcoded stack machine datapath and connects them to two buses. One register at a time drives the B bus, which feeds the right-hand ALU operand. The holding register H supplies the left-hand operand on a separate output. The ALU result comes back as the C value, and any combination of nine destinations can capture it at the clock edge. The ALU, the microsequencer and the memory sit outside the unit.

A 4-bit select field picks the B-bus driver. Nine codes are decoded, and two of them present the 8-bit fetch register widened to 32 bits in two ways: sign-extended and zero-extended. Some registers have restricted access. The memory address register and H can never reach the B bus. The fetch byte register can only be loaded from the byte-wide fetch port. The memory data register can be loaded from the word read port as well as from the C bus.

Both memory completion inputs are plain single-cycle strobes. The unit accepts every strobe in the cycle it arrives and never applies back-pressure, so the ports have no ready signal.

Top module: `mdp_reg_bus`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. After reset, `h_out`, `mar_out`, `mdr_out`, `pc_out`, `mbr_out` and the B bus under every select code all read zero.
- R2: `b_sel` codes drive the B bus as follows: 0 gives MDR, 1 gives PC, 4 gives SP, 5 gives LV, 6 gives CPP, 7 gives TOS and 8 gives OPC.
- R3: `b_sel` code 2 drives MBR sign-extended: bits 31:8 copy MBR bit 7 and bits 7:0 are MBR.
- R4: `b_sel` code 3 drives MBR zero-extended: bits 31:8 are zero and bits 7:0 are MBR.
- R5: `b_sel` codes 9 to 15 drive zero onto the B bus.
- R6: Each bit of `c_wr` is a write enable. Bit 0 is H, bit 1 OPC, bit 2 TOS, bit 3 CPP, bit 4 LV, bit 5 SP, bit 6 PC, bit 7 MDR and bit 8 MAR. Every register whose bit is set captures `c_val` at the same edge, and registers whose bit is clear keep their value.
- R7: The B bus is combinational from the current register contents. When a register is selected and written in the same cycle, the bus shows the old value during that cycle and the new value after the edge.
- R8: A `rd_word_valid` strobe loads MDR from `rd_word_data` at the next edge. If C-bus write bit 7 is set in the same cycle, the memory word wins.
- R9: MBR changes only on a `fetch_valid` strobe, which loads `fetch_byte`. No C-bus write enable affects it.
- R10: No `b_sel` code ever places MAR or H on the B bus.
- R11: H changes only when `c_wr` bit 0 is set. Memory and fetch strobes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| b_sel | input | 4 | Encoded B-bus source select |
| c_val | input | 32 | Result value arriving on the C bus |
| c_wr | input | 9 | Per-register C-bus write enables |
| rd_word_valid | input | 1 | Word read completion strobe |
| rd_word_data | input | 32 | Word returned by memory |
| fetch_valid | input | 1 | Byte fetch completion strobe |
| fetch_byte | input | 8 | Byte returned by the fetch port |
| b_bus | output | 32 | Selected B-bus value |
| h_out | output | 32 | Holding register, the left ALU operand |
| mar_out | output | 32 | Memory address register |
| mdr_out | output | 32 | Memory data register |
| pc_out | output | 32 | Fetch address register |
| mbr_out | output | 8 | Fetched byte register |

## Verification
The bench loads a byte with bit 7 set and then one with bit 7 clear, and reads both MBR views each time. A design that mixed up the two views, or took the wrong sign bit, would show wrong upper bits on codes 2 and 3. It selects SP while writing SP in the same cycle, so a bus that forwarded the C value would return the new value one cycle early. It raises a word load and a C write to MDR together, where wrong priority would leave the C value in MDR. It also writes distinctive values into MAR and H and sweeps all sixteen codes, including the unused ones. A decoder that leaked either register, or left an unused code driving something, would be caught there.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  // number of decoded B-bus sources and of C-bus destinations
  localparam int NSRC = 9;
  localparam int NWR  = 9;

  // C-bus write enable bit positions
  localparam int WR_H   = 0;
  localparam int WR_OPC = 1;
  localparam int WR_TOS = 2;
  localparam int WR_CPP = 3;
  localparam int WR_LV  = 4;
  localparam int WR_SP  = 5;
  localparam int WR_PC  = 6;
  localparam int WR_MDR = 7;
  localparam int WR_MAR = 8;

  // B-bus source codes
  typedef enum logic [3:0] {
    BS_MDR  = 4'd0,
    BS_PC   = 4'd1,
    BS_MBRS = 4'd2,
    BS_MBRU = 4'd3,
    BS_SP   = 4'd4,
    BS_LV   = 4'd5,
    BS_CPP  = 4'd6,
    BS_TOS  = 4'd7,
    BS_OPC  = 4'd8
  } bsrc_e;
endpackage

// File: rtl/mdp_bsel_dec.sv
module mdp_bsel_dec #(
  parameter int SELW = 4,
  parameter int NOUT = 9
) (
  input  logic [SELW-1:0] sel,
  output logic [NOUT-1:0] onehot
);
  for (genvar i = 0; i < NOUT; i++) begin : g_dec
    assign onehot[i] = (sel == SELW'(i));
  end
endmodule

// File: rtl/mdp_word_reg.sv
module mdp_word_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/mdp_bus_mux.sv
module mdp_bus_mux #(
  parameter int DW   = 32,
  parameter int NSRC = 9
) (
  input  logic [NSRC-1:0]         onehot,
  input  logic [NSRC-1:0][DW-1:0] src,
  output logic [DW-1:0]           bus
);
  // AND-OR selection: no select bit set yields zero
  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) begin
      bus = bus | (src[i] & {DW{onehot[i]}});
    end
  end
endmodule

// File: rtl/mdp_reg_bus.sv
module mdp_reg_bus
  import mdp_pkg::*;
#(
  parameter int DW   = 32,
  parameter int BW   = 8,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] b_sel,
  input  logic [DW-1:0]   c_val,
  input  logic [NWR-1:0]  c_wr,
  input  logic            rd_word_valid,
  input  logic [DW-1:0]   rd_word_data,
  input  logic            fetch_valid,
  input  logic [BW-1:0]   fetch_byte,
  output logic [DW-1:0]   b_bus,
  output logic [DW-1:0]   h_out,
  output logic [DW-1:0]   mar_out,
  output logic [DW-1:0]   mdr_out,
  output logic [DW-1:0]   pc_out,
  output logic [BW-1:0]   mbr_out
);
  localparam int EXTW = DW - BW;

  logic [NWR-1:0][DW-1:0]  regq;
  logic [NSRC-1:0]         src_oh;
  logic [NSRC-1:0][DW-1:0] src;
  logic [BW-1:0]           mbr_q;

  // C-bus destinations; MDR also takes memory words, which win
  for (genvar i = 0; i < NWR; i++) begin : g_reg
    if (i == WR_MDR) begin : g_mdr
      logic [DW-1:0] mdr_d;
      assign mdr_d = rd_word_valid ? rd_word_data : c_val;
      mdp_word_reg #(.W(DW)) u_r (
        .clk(clk), .rst(rst),
        .en(c_wr[i] | rd_word_valid),
        .d(mdr_d), .q(regq[i])
      );
    end else begin : g_plain
      mdp_word_reg #(.W(DW)) u_r (
        .clk(clk), .rst(rst),
        .en(c_wr[i]),
        .d(c_val), .q(regq[i])
      );
    end
  end

  // fetch byte register: byte port only
  mdp_word_reg #(.W(BW)) u_mbr (
    .clk(clk), .rst(rst),
    .en(fetch_valid),
    .d(fetch_byte), .q(mbr_q)
  );

  // B-bus source table in select-code order
  always_comb begin
    src          = '0;
    src[BS_MDR]  = regq[WR_MDR];
    src[BS_PC]   = regq[WR_PC];
    src[BS_MBRS] = {{EXTW{mbr_q[BW-1]}}, mbr_q};
    src[BS_MBRU] = {{EXTW{1'b0}}, mbr_q};
    src[BS_SP]   = regq[WR_SP];
    src[BS_LV]   = regq[WR_LV];
    src[BS_CPP]  = regq[WR_CPP];
    src[BS_TOS]  = regq[WR_TOS];
    src[BS_OPC]  = regq[WR_OPC];
  end

  mdp_bsel_dec #(.SELW(SELW), .NOUT(NSRC)) u_dec (
    .sel(b_sel), .onehot(src_oh)
  );

  mdp_bus_mux #(.DW(DW), .NSRC(NSRC)) u_mux (
    .onehot(src_oh), .src(src), .bus(b_bus)
  );

  assign h_out   = regq[WR_H];
  assign mar_out = regq[WR_MAR];
  assign mdr_out = regq[WR_MDR];
  assign pc_out  = regq[WR_PC];
  assign mbr_out = mbr_q;
endmodule

// File: rtl/mdp_reg_bus_chk.sv
module mdp_reg_bus_chk
  import mdp_pkg::*;
#(
  parameter int DW   = 32,
  parameter int BW   = 8,
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [SELW-1:0] b_sel,
  input logic [DW-1:0]   c_val,
  input logic [NWR-1:0]  c_wr,
  input logic            rd_word_valid,
  input logic [DW-1:0]   rd_word_data,
  input logic            fetch_valid,
  input logic [BW-1:0]   fetch_byte,
  input logic [DW-1:0]   b_bus,
  input logic [DW-1:0]   h_out,
  input logic [DW-1:0]   mar_out,
  input logic [DW-1:0]   mdr_out,
  input logic [DW-1:0]   pc_out,
  input logic [BW-1:0]   mbr_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (h_out == '0 && mar_out == '0 && mdr_out == '0 && pc_out == '0 && mbr_out == '0));

  // R3
  mbr_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (b_sel == SELW'(BS_MBRS)) |-> (b_bus == {{(DW-BW){mbr_out[BW-1]}}, mbr_out}));

  // R4
  mbr_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (b_sel == SELW'(BS_MBRU)) |-> (b_bus == {{(DW-BW){1'b0}}, mbr_out}));

  // R6
  multi_write_chk: assert property (@(posedge clk) disable iff (rst)
    (c_wr[WR_H] && c_wr[WR_MAR]) |=> (h_out == mar_out));

  // R8
  mdr_load_chk: assert property (@(posedge clk) disable iff (rst)
    rd_word_valid |=> (mdr_out == $past(rd_word_data)));

  // R9
  mbr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> $stable(mbr_out));

  // R11
  h_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !c_wr[WR_H] |=> $stable(h_out));

  // R7
  bus_old_value_chk: assert property (@(posedge clk) disable iff (rst)
    (b_sel == SELW'(BS_PC) && c_wr[WR_PC]) |-> (b_bus == pc_out));
endmodule

bind mdp_reg_bus mdp_reg_bus_chk #(.DW(DW), .BW(BW), .SELW(SELW)) u_chk (.*);

// File: tb/sim_mdp_reg_bus.sv
module sim_mdp_reg_bus;
  localparam int DW = 32;
  localparam int BW = 8;
  localparam int SELW = 4;
  localparam int NW = 9;
  localparam int WATCHDOG_CYC = 200000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [SELW-1:0] b_sel = '0;
  logic [DW-1:0]   c_val = '0;
  logic [NW-1:0]   c_wr = '0;
  logic            rd_word_valid = 1'b0;
  logic [DW-1:0]   rd_word_data = '0;
  logic            fetch_valid = 1'b0;
  logic [BW-1:0]   fetch_byte = '0;
  logic [DW-1:0]   b_bus, h_out, mar_out, mdr_out, pc_out;
  logic [BW-1:0]   mbr_out;

  always #10 clk = ~clk;  // 50 MHz

  mdp_reg_bus #(.DW(DW), .BW(BW), .SELW(SELW)) u0 (
    .clk(clk), .rst(rst), .b_sel(b_sel), .c_val(c_val), .c_wr(c_wr),
    .rd_word_valid(rd_word_valid), .rd_word_data(rd_word_data),
    .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
    .b_bus(b_bus), .h_out(h_out), .mar_out(mar_out), .mdr_out(mdr_out),
    .pc_out(pc_out), .mbr_out(mbr_out)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state: index is the write-enable bit (0 H .. 8 MAR)
  logic [DW-1:0] mr [NW];
  logic [BW-1:0] mbr_m;

  logic [DW-1:0] exp_q [$];
  string         req_q [$];
  event          samp_ev;

  function automatic logic [DW-1:0] exp_bus(input int sel);
    case (sel)
      0: return mr[7];
      1: return mr[6];
      2: return {{(DW-BW){mbr_m[BW-1]}}, mbr_m};
      3: return {{(DW-BW){1'b0}}, mbr_m};
      4: return mr[5];
      5: return mr[4];
      6: return mr[3];
      7: return mr[2];
      8: return mr[1];
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected B-bus values as the design presents them
  initial begin
    forever begin
      @(samp_ev);
      if (exp_q.size() != 0) begin
        chk(req_q.pop_front(), b_bus, exp_q.pop_front());
      end
    end
  end

  // driver: one cycle of stimulus, expected bus pushed before the edge
  task automatic step(input string req, input int sel, input logic [NW-1:0] wr,
                      input logic [DW-1:0] cv, input logic wv, input logic [DW-1:0] wd,
                      input logic fv, input logic [BW-1:0] fb, input logic r);
    @(negedge clk);
    rst = r; b_sel = SELW'(sel); c_wr = wr; c_val = cv;
    rd_word_valid = wv; rd_word_data = wd; fetch_valid = fv; fetch_byte = fb;
    #2;
    if (!r) begin
      exp_q.push_back(exp_bus(sel));
      req_q.push_back(req);
      ->samp_ev;
    end
    if (r) begin
      for (int i = 0; i < NW; i++) mr[i] = '0;
      mbr_m = '0;
    end else begin
      for (int i = 0; i < NW; i++) if (wr[i]) mr[i] = cv;
      if (wv) mr[7] = wd;
      if (fv) mbr_m = fb;
    end
    @(posedge clk);
    #1;
    rst = 1'b0; c_wr = '0; rd_word_valid = 1'b0; fetch_valid = 1'b0;
  endtask

  task automatic look(input string req, input int sel);
    step(req, sel, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic check_regs(input string req);
    chk(req, h_out, mr[0]);
    chk(req, mar_out, mr[8]);
    chk(req, mdr_out, mr[7]);
    chk(req, pc_out, mr[6]);
    chk(req, {{(DW-BW){1'b0}}, mbr_out}, {{(DW-BW){1'b0}}, mbr_m});
  endtask

  task automatic finish_sim();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * WATCHDOG_CYC);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) mr[i] = '0;
    mbr_m = '0;
    // reset state, R1
    step("R1", 0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b1);
    step("R1", 0, '1, 32'hFFFF_FFFF, 1'b1, 32'h1, 1'b1, 8'hFF, 1'b1);
    check_regs("R1");
    for (int s = 0; s < 16; s++) look("R1", s);

    // load each C destination with its own value, R6
    for (int i = 0; i < NW; i++) begin
      step("R6", 15, NW'(1) << i, 32'hA500_0000 + 32'(i) * 32'h0011_1111,
           1'b0, '0, 1'b0, '0, 1'b0);
    end
    check_regs("R6");
    // sweep all codes: R2 for 0,1,4-8 and R5 for 9-15
    for (int s = 0; s < 9; s++) look("R2", s);
    for (int s = 9; s < 16; s++) look("R5", s);

    // negative byte then positive byte, R3 and R4
    step("R9", 15, '0, '0, 1'b0, '0, 1'b1, 8'h85, 1'b0);
    look("R3", 2);
    look("R4", 3);
    step("R9", 15, '0, '0, 1'b0, '0, 1'b1, 8'h7A, 1'b0);
    look("R3", 2);
    look("R4", 3);
    chk("R9", {24'h0, mbr_out}, 32'h7A);

    // all enables at once: every destination equal, MBR untouched, R6 R9
    step("R6", 15, '1, 32'hDEAD_BEEF, 1'b0, '0, 1'b0, '0, 1'b0);
    check_regs("R6");
    chk("R9", {24'h0, mbr_out}, 32'h7A);
    for (int s = 0; s < 9; s++) look("R6", s);

    // same-cycle read and write of SP and PC, R7
    step("R7", 4, NW'(1) << 5, 32'h0BAD_F00D, 1'b0, '0, 1'b0, '0, 1'b0);
    look("R7", 4);
    step("R7", 1, NW'(1) << 6, 32'h0000_1234, 1'b0, '0, 1'b0, '0, 1'b0);
    look("R7", 1);

    // memory word against C write to MDR, R8
    step("R8", 0, NW'(1) << 7, 32'h1111_2222, 1'b1, 32'h3333_4444, 1'b0, '0, 1'b0);
    chk("R8", mdr_out, 32'h3333_4444);
    look("R8", 0);
    step("R8", 15, '0, '0, 1'b1, 32'h5555_6666, 1'b0, '0, 1'b0);
    chk("R8", mdr_out, 32'h5555_6666);

    // MAR and H hidden from the bus, R10
    step("R10", 15, NW'(1) << 8, 32'h1357_9BDF, 1'b0, '0, 1'b0, '0, 1'b0);
    step("R10", 15, NW'(1) << 0, 32'h2468_ACE0, 1'b0, '0, 1'b0, '0, 1'b0);
    for (int s = 0; s < 16; s++) begin
      look("R10", s);
      checks++;
      if (b_bus == 32'h1357_9BDF || b_bus == 32'h2468_ACE0) begin
        errors++;
        $display("FAIL R10: got %h expected neither MAR nor H", b_bus);
      end
    end

    // H unaffected by memory and fetch strobes, R11
    step("R11", 15, '0, '0, 1'b1, 32'h7777_8888, 1'b1, 8'hC3, 1'b0);
    chk("R11", h_out, 32'h2468_ACE0);
    check_regs("R11");

    #5;
    finish_sim();
  end
endmodule